// File: doc/BRIEF.md
# Scan Cell Test Applicator

This block tests one configurable logic cell from a boundary-scan style access path. A host drives a 13-bit user data register through shift, capture and update strobes. An update copies the whole register onto the cell's stimulus lines in one step. The cell has two identical halves, and both take the same 13 stimulus bits at the same time. Each half returns 6 response bits.

On a capture, the block latches both 6-bit responses into the scan register, where the host can shift them out. If a vector has been applied since the previous capture, the block also compares each half against the expected response for the current vector index. A small table computed inside the block supplies that value. A mismatch on either half raises a separate sticky flag, so a fault is traced to one half and not only to the cell.

A vector counter walks through the 40 vectors of one full test and raises done after the last comparison.

Top module: `scan_cell_tester`

## Requirements
- R1: After reset, cell_stim, vec_idx, done, fail_a, fail_b and tdo are all zero.
- R2: The strobes act only while dr_sel is high. On a shift cycle, the register moves one place toward bit 0, tdi enters bit 12, and tdo always shows bit 0, so the host sends bit 0 of a vector first.
- R3: cell_stim changes only in the cycle after an update strobe, and then it takes all 13 register bits. Shifting never disturbs it.
- R4: A capture loads the register with resp_a in bits 5:0, resp_b in bits 11:6 and zero in bit 12. Capture takes priority over a shift in the same cycle.
- R5: A capture compares and advances only if an update happened after the previous capture (or after reset or restart). Otherwise vec_idx and the flags do not change.
- R6: Vector k is (k*2897+311) mod 8192. The expected response of each half to a vector v is v[5:0] ^ v[11:6] ^ {6{v[12]}}. Each half is compared separately, and a mismatch sets only that half's flag.
- R7: fail_a and fail_b stay set until clear_fail. If a clear and a mismatch on the same half fall in the same cycle, that flag stays set. restart does not touch the flags.
- R8: Each comparison moves vec_idx up by one, from 0. The comparison at index 39 sets done and vec_idx stays at 39. While done is set, captures make no comparison. restart returns vec_idx and done to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dr_sel | input | 1 | User data register selected |
| dr_capture | input | 1 | Capture strobe |
| dr_shift | input | 1 | Shift strobe |
| dr_update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (register bit 0) |
| cell_stim | output | 13 | Stimulus to both cell halves |
| resp_a | input | 6 | Response of half A |
| resp_b | input | 6 | Response of half B |
| restart | input | 1 | Return to vector 0, clear done |
| clear_fail | input | 1 | Clear both fail flags |
| vec_idx | output | 6 | Current vector index |
| done | output | 1 | All vectors compared |
| fail_a | output | 1 | Sticky mismatch flag, half A |
| fail_b | output | 1 | Sticky mismatch flag, half B |

## Verification
Two functions can fall in the same cycle: a flag clear and a comparison that fails, which sets a flag. The bench holds fail_b set from an earlier run. It then applies vector 0 with a fault injected on half A and pulses capture and clear_fail together. The expected outcome is fail_a set (the new mismatch survives the clear) and fail_b cleared. A second pairing puts capture against a pending shift; the bench judges it by reading the captured word back through tdo, bit by bit, during the next shift-in.

// File: rtl/scan_cell_tester.sv
module scan_cell_tester #(
  parameter int DR_W    = 13,
  parameter int HALF_W  = 6,
  parameter int VEC_CNT = 40,
  parameter int VEC_MUL = 2897,
  parameter int VEC_ADD = 311,
  parameter int IDX_W   = $clog2(VEC_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dr_sel,
  input  logic              dr_capture,
  input  logic              dr_shift,
  input  logic              dr_update,
  input  logic              tdi,
  output logic              tdo,
  output logic [DR_W-1:0]   cell_stim,
  input  logic [HALF_W-1:0] resp_a,
  input  logic [HALF_W-1:0] resp_b,
  input  logic              restart,
  input  logic              clear_fail,
  output logic [IDX_W-1:0]  vec_idx,
  output logic              done,
  output logic              fail_a,
  output logic              fail_b
);
  localparam int RESP_W = 2 * HALF_W;

  function automatic logic [DR_W-1:0] vec_of(input int k);
    logic [31:0] t;
    t = k * VEC_MUL + VEC_ADD;
    return t[DR_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] good_half(input logic [DR_W-1:0] v);
    return v[HALF_W-1:0] ^ v[RESP_W-1:HALF_W] ^ {HALF_W{v[RESP_W]}};
  endfunction

  logic [DR_W-1:0]   sr;
  logic              armed;
  logic [HALF_W-1:0] exp_half;

  wire cap = dr_sel & dr_capture;
  wire sh  = dr_sel & dr_shift & ~dr_capture;
  wire upd = dr_sel & dr_update;
  wire cmp = cap & armed & ~done;

  assign exp_half = good_half(vec_of(int'(vec_idx)));
  assign tdo      = sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= '0;
      cell_stim <= '0;
    end else begin
      if (cap)      sr <= DR_W'({resp_b, resp_a});
      else if (sh)  sr <= {tdi, sr[DR_W-1:1]};
      if (upd)      cell_stim <= sr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      vec_idx <= '0;
      done    <= 1'b0;
    end else begin
      if (restart)  armed <= 1'b0;
      else if (upd) armed <= 1'b1;
      else if (cap) armed <= 1'b0;
      if (restart) begin
        vec_idx <= '0;
        done    <= 1'b0;
      end else if (cmp) begin
        if (vec_idx == IDX_W'(VEC_CNT - 1)) done <= 1'b1;
        else                                vec_idx <= vec_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_a <= 1'b0;
      fail_b <= 1'b0;
    end else begin
      fail_a <= (fail_a & ~clear_fail) | (cmp & (resp_a != exp_half));
      fail_b <= (fail_b & ~clear_fail) | (cmp & (resp_b != exp_half));
    end
  end

  assert_stim_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dr_sel && dr_update) |=> $stable(cell_stim));
  assert_sticky_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_a && !clear_fail |=> fail_a);
  assert_sticky_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_b && !clear_fail |=> fail_b);
  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_idx < IDX_W'(VEC_CNT));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !restart |=> done && $stable(vec_idx));
  assert_no_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dr_sel && dr_capture) && !restart |=> $stable(vec_idx));
  assert_capture_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dr_sel && dr_capture |=> tdo == $past(resp_a[0]));
endmodule

// File: tb/scan_cell_tester_tb.sv
module scan_cell_tester_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dr_sel = 1'b1, dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
  logic restart = 1'b0, clear_fail = 1'b0;
  logic tdo, done, fail_a, fail_b;
  logic [12:0] cell_stim;
  logic [5:0] resp_a, resp_b, inj_a = '0, inj_b = '0, vec_idx;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [12:0] vecf(input int k);
    logic [31:0] t;
    t = k * 2897 + 311;
    return t[12:0];
  endfunction
  function automatic logic [5:0] halff(input logic [12:0] v);
    return v[5:0] ^ v[11:6] ^ {6{v[12]}};
  endfunction

  assign resp_a = halff(cell_stim) ^ inj_a;
  assign resp_b = halff(cell_stim) ^ inj_b;

  scan_cell_tester dut_i (
    .clk(clk), .rst_n(rst_n), .dr_sel(dr_sel), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .tdi(tdi), .tdo(tdo),
    .cell_stim(cell_stim), .resp_a(resp_a), .resp_b(resp_b), .restart(restart),
    .clear_fail(clear_fail), .vec_idx(vec_idx), .done(done),
    .fail_a(fail_a), .fail_b(fail_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [12:0] readout;
  task automatic shift_in(input logic [12:0] v, input logic [12:0] stim_now);
    readout = '0;
    for (int i = 0; i < 13; i++) begin
      readout[i] = tdo;
      tdi = v[i]; dr_shift = 1'b1;
      @(negedge clk);
      if (i == 6) check("R3 stim held mid-shift", cell_stim, stim_now);
    end
    dr_shift = 1'b0;
  endtask
  task automatic update();
    dr_update = 1'b1; @(negedge clk); dr_update = 1'b0;
  endtask
  task automatic capture();
    dr_capture = 1'b1; @(negedge clk); dr_capture = 1'b0;
  endtask
  task automatic do_restart();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  task automatic run(input int fvec, input logic [5:0] ma, input logic [5:0] mb);
    logic [12:0] last;
    bit exp_fa, exp_fb;
    exp_fa = 1'b0; exp_fb = 1'b0;
    last = '0;
    do_restart();
    check("R8 restart idx", vec_idx, 0);
    for (int k = 0; k < 40; k++) begin
      shift_in(vecf(k), cell_stim);
      if (k > 0) check("R4 readout via tdo", readout, last);
      update();
      check("R3 stim applied", cell_stim, vecf(k));
      if (k == fvec) begin inj_a = ma; inj_b = mb; end
      last = 13'({halff(vecf(k)) ^ inj_b, halff(vecf(k)) ^ inj_a});
      capture();
      inj_a = '0; inj_b = '0;
      if (k == fvec) begin exp_fa = (ma != 0); exp_fb = (mb != 0); end
      check("R6 half A flag", fail_a, exp_fa);
      check("R6 half B flag", fail_b, exp_fb);
      check("R8 index", vec_idx, (k == 39) ? 39 : k + 1);
      check("R8 done", done, k == 39);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 stim", cell_stim, 0);
    check("R1 idx", vec_idx, 0);
    check("R1 done", done, 0);
    check("R1 fails", {fail_a, fail_b}, 0);
    check("R1 tdo", tdo, 0);

    run(99, 0, 0);
    shift_in(vecf(3), cell_stim); update();
    inj_a = 6'h3F; capture(); inj_a = '0;
    check("R8 no compare when done", {fail_a, fail_b}, 0);
    check("R8 idx holds at done", vec_idx, 39);

    run(17, 6'h04, 0);
    check("R7 sticky A to end", fail_a, 1);
    clear_fail = 1'b1; @(negedge clk); clear_fail = 1'b0;
    check("R7 clear A", fail_a, 0);

    run(0, 0, 6'h20);
    check("R7 sticky B, A clean", {fail_a, fail_b}, 2'b01);

    do_restart();
    check("R7 restart keeps flags", fail_b, 1);
    shift_in(vecf(0), cell_stim); update();
    inj_a = 6'h01; dr_capture = 1'b1; clear_fail = 1'b1;
    @(negedge clk);
    dr_capture = 1'b0; clear_fail = 1'b0; inj_a = '0;
    check("R7 mismatch beats clear", fail_a, 1);
    check("R7 clear B same cycle", fail_b, 0);
    check("R5 idx after compare", vec_idx, 1);

    inj_b = 6'h02; capture(); inj_b = '0;
    check("R5 capture w/o update idx", vec_idx, 1);
    check("R5 capture w/o update flag", fail_b, 0);

    dr_capture = 1'b1; dr_shift = 1'b1; tdi = 1'b1; @(negedge clk);
    dr_capture = 1'b0; dr_shift = 1'b0;
    shift_in(13'h0, cell_stim);
    check("R4 capture beats shift", readout, 13'({halff(cell_stim), halff(cell_stim)}));

    dr_sel = 1'b0;
    shift_in(13'h1ABC, cell_stim);
    update();
    check("R2 deselected update", cell_stim, vecf(0));
    dr_sel = 1'b1;
    shift_in(13'h0, cell_stim);
    check("R2 deselected shift kept reg", readout, 13'h0);
    shift_in(13'h0A5A, cell_stim);
    shift_in(13'h0, cell_stim);
    check("R2 serial order", readout, 13'h0A5A);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule